// File: doc/BRIEF.md
# FM Synthesizer Host Register Decoder

This block is the host-facing register front end of an FM synthesizer with two register banks and eighteen two-operator channels. The host writes through a four-entry port window. Two of the entries latch a 9-bit register address, where bit 8 selects the bank. The other two entries carry data that lands on the latched address. Each data write is decoded into an operator index or a channel index, plus a one-hot field strobe. The downstream voice engine uses the strobe, the index and the data byte to update its own per-operator state.

A few parameters are held in the block itself: the global mode bits, the pairing enables, the channel configuration bytes and the waveform selects. The block runs in one of two modes. In compatibility mode the second bank is hidden, apart from the mode register, and waveforms are limited to four shapes. Enhanced mode opens both banks and all eight shapes.

Top module: `fm_reg_front`

## Requirements
- R1: A write with `port_sel`=0 latches `addr_q` = {0, data} on that clock edge. Port 1 and port 3 are both data ports and behave identically.
- R2: With `enh_mode`=0, a write to port 2 latches {1, data} when data is 0x05, and {0, data} for any other value.
- R3: With `enh_mode`=1, a write to port 2 latches `addr_q` = {1, data}.
- R4: A data write to address 0x105 sets `enh_mode` from data bit 0. A data write to 0x104 sets `pair_en` from data bits 5:0. A data write to 0x101 changes nothing and produces no strobe.
- R5: Operator registers are the groups at offsets 0x20, 0x40, 0x60, 0x80 and 0xE0 of each bank. Within a group, offset bits 4:3 give a row r (0 to 2) and bits 2:0 give a position p. Positions 0 to 2 map to operator 6r+2p. Positions 3 to 5 map to operator 6r+2(p-3)+1. Positions 6 and 7, and row 3, produce no strobe. The field bits are: bit 0 for 0x20, bit 1 for 0x40, bit 2 for 0x60, bit 3 for 0x80, bit 4 for 0xE0.
- R6: In bank 1, the operator index is the bank-0 result plus 18, and the channel index is the bank-0 result plus 9. For operator writes, `stb_ch` is the operator index divided by two.
- R7: Channel registers are 0xA0 to 0xA8 (field bit 5), 0xB0 to 0xB8 (field bit 6) and 0xC0 to 0xC8 (field bit 7). The channel is the low nibble. A low nibble above 8, and any address from 0xD0 to 0xDF, produce no strobe. Register 0x004 produces no strobe either.
- R8: A write to the 0xE0 group stores data bits 2:0 for that operator, at `wave_all[3n+2:3n]`. The bit 2 of the effective output reads 0 while `enh_mode`=0, and the stored bit 2 reappears once `enh_mode` is set.
- R9: A write to the 0xC0 group stores feedback = data[3:1] at `fb_all[3c+2:3c]` and connection = data[0] at `conn_all[c]`. In enhanced mode it also sets `out_en_a[c]` = data[4] and `out_en_b[c]` = data[5]. In compatibility mode both enables are set to 1.
- R10: A data write to offset 0x08 of either bank sets `note_sel` from data bit 6.
- R11: A decoded write raises exactly one `stb_field` bit for the one cycle after the write edge, with `stb_op`, `stb_ch` and `stb_data` valid during that cycle. Without a decoded write, all four strobe outputs are 0.
- R12: An active-low reset clears the address, the mode, the pairing and note bits, all stored parameters and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| port_sel | input | 2 | Port window entry: 0 and 2 are address ports, 1 and 3 are data ports |
| wr_data | input | 8 | Host write byte |
| addr_q | output | 9 | Latched register address, where bit 8 is the bank |
| enh_mode | output | 1 | Enhanced mode enable |
| pair_en | output | 6 | Four-operator pairing enables |
| note_sel | output | 1 | Note-select bit |
| stb_field | output | 8 | One-hot field-write strobe |
| stb_op | output | 6 | Operator index of the strobed write |
| stb_ch | output | 5 | Channel index of the strobed write |
| stb_data | output | 8 | Data byte of the strobed write |
| out_en_a | output | 18 | Per-channel output A enable |
| out_en_b | output | 18 | Per-channel output B enable |
| fb_all | output | 54 | Per-channel feedback, 3 bits each |
| conn_all | output | 18 | Per-channel connection bit |
| wave_all | output | 108 | Per-operator effective waveform, 3 bits each |

## Verification
The assertions assume that `wr_en`, `port_sel` and `wr_data` are stable across each rising edge. They also assume that a data write and a mode change never land on the same edge, so the mode that applies to a channel-configuration write is the mode of the cycle in which the write is made. The stimulus meets both assumptions. It changes inputs only on falling edges, and it issues every write as a separate one-cycle pulse, with address and data writes on separate clocks. Mode changes are made only through dedicated writes to 0x105.

// File: rtl/fm_reg_front.sv
module fm_reg_front (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   port_sel,
  input  logic [7:0]   wr_data,
  output logic [8:0]   addr_q,
  output logic         enh_mode,
  output logic [5:0]   pair_en,
  output logic         note_sel,
  output logic [7:0]   stb_field,
  output logic [5:0]   stb_op,
  output logic [4:0]   stb_ch,
  output logic [7:0]   stb_data,
  output logic [17:0]  out_en_a,
  output logic [17:0]  out_en_b,
  output logic [53:0]  fb_all,
  output logic [17:0]  conn_all,
  output logic [107:0] wave_all
);

  localparam int NOP = 36;
  localparam int NCH = 18;

  logic       addr_wr, data_wr;
  logic [8:0] addr_nx;
  logic       bank;
  logic [7:0] lo;
  logic [2:0] grp;
  logic [4:0] off;
  logic       op_ok, ch_ok;
  logic [4:0] op_local;
  logic [5:0] op_num;
  logic [4:0] ch_num;
  logic [7:0] fld;
  logic [107:0] wave_raw;

  assign addr_wr = wr_en & ~port_sel[0];
  assign data_wr = wr_en &  port_sel[0];
  assign addr_nx = {port_sel[1] & (enh_mode | (wr_data == 8'h05)), wr_data};

  assign bank = addr_q[8];
  assign lo   = addr_q[7:0];
  assign grp  = lo[7:5];
  assign off  = lo[4:0];

  always_comb begin
    op_ok = (grp == 3'd1 || grp == 3'd2 || grp == 3'd3 || grp == 3'd4 || grp == 3'd7)
            && (off[4:3] != 2'd3) && (off[2:1] != 2'b11);
    if (off[2:0] < 3'd3) op_local = 5'(off[4:3]) * 5'd6 + 5'(off[2:0]) * 5'd2;
    else                 op_local = 5'(off[4:3]) * 5'd6 + (5'(off[2:0]) - 5'd3) * 5'd2 + 5'd1;
    op_num = 6'(op_local) + (bank ? 6'd18 : 6'd0);
    ch_ok  = ((grp == 3'd5) || (grp == 3'd6 && !lo[4])) && (lo[3:0] <= 4'd8);
    ch_num = 5'(lo[3:0]) + (bank ? 5'd9 : 5'd0);
    fld = 8'h00;
    case (grp)
      3'd1: fld = 8'h01;
      3'd2: fld = 8'h02;
      3'd3: fld = 8'h04;
      3'd4: fld = 8'h08;
      3'd7: fld = 8'h10;
      3'd5: fld = lo[4] ? 8'h40 : 8'h20;
      3'd6: fld = 8'h80;
      default: fld = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      enh_mode  <= 1'b0;
      pair_en   <= '0;
      note_sel  <= 1'b0;
      stb_field <= '0;
      stb_op    <= '0;
      stb_ch    <= '0;
      stb_data  <= '0;
      out_en_a  <= '0;
      out_en_b  <= '0;
      fb_all    <= '0;
      conn_all  <= '0;
      wave_raw  <= '0;
    end else begin
      stb_field <= '0;
      stb_op    <= '0;
      stb_ch    <= '0;
      stb_data  <= '0;
      if (addr_wr) addr_q <= addr_nx;
      if (data_wr) begin
        if (addr_q == 9'h105) enh_mode <= wr_data[0];
        if (addr_q == 9'h104) pair_en  <= wr_data[5:0];
        if (lo == 8'h08)      note_sel <= wr_data[6];
        if (op_ok) begin
          stb_field <= fld;
          stb_op    <= op_num;
          stb_ch    <= op_num[5:1];
          stb_data  <= wr_data;
          if (grp == 3'd7) wave_raw[3*op_num +: 3] <= wr_data[2:0];
        end else if (ch_ok) begin
          stb_field <= fld;
          stb_ch    <= ch_num;
          stb_data  <= wr_data;
          if (grp == 3'd6) begin
            fb_all[3*ch_num +: 3] <= wr_data[3:1];
            conn_all[ch_num]      <= wr_data[0];
            out_en_a[ch_num]      <= enh_mode ? wr_data[4] : 1'b1;
            out_en_b[ch_num]      <= enh_mode ? wr_data[5] : 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NOP; g++) begin : g_wave
    assign wave_all[3*g +: 3] = {wave_raw[3*g+2] & enh_mode, wave_raw[3*g +: 2]};
  end

  // R1
  addr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 2'd0) |=> (addr_q == {1'b0, $past(wr_data)}));

  // R2
  compat_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 2'd2 && !enh_mode) |=>
      (addr_q[8] == ($past(wr_data) == 8'h05)) && (addr_q[7:0] == $past(wr_data)));

  // R3
  enh_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 2'd2 && enh_mode) |=> (addr_q == {1'b1, $past(wr_data)}));

  // R4
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel[0] && addr_q == 9'h105) |=> (enh_mode == $past(wr_data[0])));

  // R4
  test_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel[0] && addr_q == 9'h101) |=>
      ($stable(enh_mode) && $stable(pair_en) && stb_field == 8'h00));

  // R5
  op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_field[4:0] != 5'd0) |-> (stb_op < 6'(NOP)));

  // R7
  ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_field[7:5] != 3'd0) |-> (stb_ch < 5'(NCH) && stb_op == 6'd0));

  // R9
  compat_pan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_field[7] && !$past(enh_mode)) |-> (out_en_a[stb_ch] && out_en_b[stb_ch]));

  // R11
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_field));

  // R11
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_field != 8'h00) |-> $past(wr_en && port_sel[0]));

endmodule

// File: tb/fm_reg_front_test.sv
module fm_reg_front_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   port_sel = 2'd0;
  logic [7:0]   wr_data = 8'h00;
  logic [8:0]   addr_q;
  logic         enh_mode;
  logic [5:0]   pair_en;
  logic         note_sel;
  logic [7:0]   stb_field;
  logic [5:0]   stb_op;
  logic [4:0]   stb_ch;
  logic [7:0]   stb_data;
  logic [17:0]  out_en_a, out_en_b, conn_all;
  logic [53:0]  fb_all;
  logic [107:0] wave_all;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fm_reg_front uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
    .addr_q(addr_q), .enh_mode(enh_mode), .pair_en(pair_en), .note_sel(note_sel),
    .stb_field(stb_field), .stb_op(stb_op), .stb_ch(stb_ch), .stb_data(stb_data),
    .out_en_a(out_en_a), .out_en_b(out_en_b), .fb_all(fb_all), .conn_all(conn_all),
    .wave_all(wave_all)
  );

  // {addr[8:0], data[7:0], field[7:0], op[5:0], ch[4:0]}, enhanced mode on
  localparam logic [35:0] VEC [19] = '{
    {9'h020, 8'h11, 8'h01, 6'd0,  5'd0},
    {9'h043, 8'h22, 8'h02, 6'd1,  5'd0},
    {9'h06D, 8'h33, 8'h04, 6'd11, 5'd5},
    {9'h092, 8'h44, 8'h08, 6'd16, 5'd8},
    {9'h0F5, 8'h05, 8'h10, 6'd17, 5'd8},
    {9'h121, 8'h66, 8'h01, 6'd20, 5'd10},
    {9'h1EC, 8'h02, 8'h10, 6'd27, 5'd13},
    {9'h0A4, 8'h77, 8'h20, 6'd0,  5'd4},
    {9'h0B8, 8'h88, 8'h40, 6'd0,  5'd8},
    {9'h1A0, 8'h99, 8'h20, 6'd0,  5'd9},
    {9'h1C8, 8'h31, 8'h80, 6'd0,  5'd17},
    {9'h0C3, 8'h0E, 8'h80, 6'd0,  5'd3},
    {9'h026, 8'hAA, 8'h00, 6'd0,  5'd0},
    {9'h03A, 8'hAB, 8'h00, 6'd0,  5'd0},
    {9'h0A9, 8'hAC, 8'h00, 6'd0,  5'd0},
    {9'h0D0, 8'hAD, 8'h00, 6'd0,  5'd0},
    {9'h0BD, 8'hAE, 8'h00, 6'd0,  5'd0},
    {9'h004, 8'hAF, 8'h00, 6'd0,  5'd0},
    {9'h19B, 8'h10, 8'h00, 6'd0,  5'd0}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wport(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_sel = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_addr(input logic [8:0] a);
    wport(a[8] ? 2'd2 : 2'd0, a[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R12 act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset addr", 128'(addr_q), 0);
    chk("R12 reset mode", 128'({enh_mode, pair_en, note_sel}), 0);
    chk("R12 reset strobes", 128'({stb_field, stb_op, stb_ch, stb_data}), 0);
    chk("R12 reset store", 128'({out_en_a, out_en_b, conn_all, fb_all}), 0);
    chk("R12 reset wave", 128'(wave_all), 0);

    // compatibility mode: port 2 aliases to bank 0 (R2)
    wport(2'd2, 8'h20);
    chk("R2 compat alias", 128'(addr_q), 128'h020);
    wport(2'd0, 8'hE0);
    wport(2'd3, 8'h07);
    chk("R5 wave strobe port3 R1", 128'({stb_field, stb_op}), 128'({8'h10, 6'd0}));
    chk("R8 compat wave masked", 128'(wave_all[2:0]), 128'd3);
    wport(2'd0, 8'hC0);
    wport(2'd1, 8'h04);
    chk("R9 compat pan forced", 128'({out_en_a[0], out_en_b[0], fb_all[2:0], conn_all[0]}),
        128'({1'b1, 1'b1, 3'd2, 1'b0}));
    wport(2'd2, 8'h05);
    chk("R2 compat mode reg", 128'(addr_q), 128'h105);
    wport(2'd1, 8'h01);
    chk("R4 enhanced on", 128'(enh_mode), 1);
    chk("R8 stored 3 bits", 128'(wave_all[2:0]), 128'd7);
    wport(2'd2, 8'h20);
    chk("R3 enhanced bank1", 128'(addr_q), 128'h120);

    for (int i = 0; i < 19; i++) begin
      logic [35:0] v;
      v = VEC[i];
      set_addr(v[35:27]);
      wport(2'd1, v[26:19]);
      chk($sformatf("R5 R6 R7 R11 vec%0d field", i), 128'(stb_field), 128'(v[18:11]));
      chk($sformatf("R5 R6 vec%0d op", i), 128'(stb_op), 128'(v[10:5]));
      chk($sformatf("R6 R7 vec%0d ch", i), 128'(stb_ch), 128'(v[4:0]));
      chk($sformatf("R11 vec%0d data", i), 128'(stb_data),
          128'((v[18:11] != 8'h00) ? v[26:19] : 8'h00));
      @(negedge clk);
      chk($sformatf("R11 vec%0d one cycle", i), 128'(stb_field), 0);
    end

    chk("R8 op17 wave", 128'(wave_all[3*17 +: 3]), 128'd5);
    chk("R8 op27 wave", 128'(wave_all[3*27 +: 3]), 128'd2);
    chk("R9 ch17 enh pan", 128'({out_en_a[17], out_en_b[17], conn_all[17], fb_all[3*17 +: 3]}),
        128'({1'b1, 1'b1, 1'b1, 3'd0}));
    chk("R9 ch3 enh pan", 128'({out_en_a[3], out_en_b[3], conn_all[3], fb_all[3*3 +: 3]}),
        128'({1'b0, 1'b0, 1'b0, 3'd7}));

    wport(2'd2, 8'hC1);
    wport(2'd1, 8'h20);
    chk("R9 bank1 ch10 B only", 128'({out_en_a[10], out_en_b[10]}), 128'(2'b01));

    wport(2'd2, 8'h04);
    wport(2'd1, 8'hEA);
    chk("R4 pairing", 128'(pair_en), 128'h2A);
    wport(2'd0, 8'h08);
    wport(2'd1, 8'h40);
    chk("R10 note bank0", 128'(note_sel), 1);
    wport(2'd2, 8'h01);
    wport(2'd1, 8'hFF);
    chk("R4 test reg ignored", 128'({enh_mode, pair_en, note_sel, stb_field}),
        128'({1'b1, 6'h2A, 1'b1, 8'h00}));
    wport(2'd2, 8'h08);
    wport(2'd3, 8'hBF);
    chk("R10 note bank1", 128'(note_sel), 0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R12 mid reset", 128'({addr_q, enh_mode, pair_en, note_sel, out_en_a, conn_all}), 0);
    chk("R12 mid reset wave", 128'(wave_all), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule